// File: doc/BRIEF.md
# AHB-Lite Wait-State Memory Slave

This block is a small RAM that sits behind an AHB-Lite bus as a single slave. The master presents an address, a direction, a transfer size and a transfer type in one cycle. The slave moves the data in the cycle or cycles that follow. The address phase of the next transfer overlaps that data phase, so transfers are pipelined. A parameter sets how many wait cycles the slave holds its ready output low before each active transfer completes. Setting it to zero gives single-cycle transfers.

Idle and busy cycles are answered at once with an OKAY response and never touch the storage. An active transfer to a word outside the implemented range, or one wider than the 32-bit data bus, gets the two-cycle ERROR response. Byte and halfword writes change only the byte lanes that the low address bits and the size select. Reads always return the whole 32-bit word.

Top module: `ahbl_wait_mem`

## Requirements
- R1: After reset, readyOut is 1, errResp is 0, rdData is 0, and every storage word reads as 0.
- R2: Address and control are taken at every rising edge where readyOut is 1. The data of that transfer moves in the following cycles. A read issued in the data phase of a write to the same word returns the newly written value.
- R3: An active in-range transfer holds readyOut low for exactly WAIT_STATES cycles of its data phase, then drives it high with errResp 0. With WAIT_STATES = 0, readyOut never goes low for such a transfer.
- R4: rdData carries the addressed 32-bit word only in the cycle where a read completes (readyOut high). In every other cycle it is 0.
- R5: A write stores wrData as it stands in the completing cycle. The master holds wrData stable through the wait cycles.
- R6: Byte lane k is bits 8k+7 down to 8k. A write with reqSize 0 updates only lane reqAddr[1:0]. A write with reqSize 1 updates lanes 1:0 when reqAddr[1] is 0, and lanes 3:2 when it is 1. A write with reqSize 2 updates all four lanes.
- R7: A transfer with reqTrans 00 (idle) or 01 (busy) gets readyOut 1 and errResp 0 with no wait cycle, and it changes no storage.
- R8: An active transfer whose word index reqAddr[ADDR_W-1:2] is DEPTH_WORDS or more gets an ERROR response and writes nothing. The response is one cycle with readyOut 0 and errResp 1, then one cycle with readyOut 1 and errResp 1.
- R9: An active transfer with reqSize greater than 2 gets the same two-cycle ERROR response as R8 and writes nothing.
- R10: reqTrans bit 1 marks an active transfer: 10 is non-sequential and 11 is sequential. Both are served identically. reqWrite 1 means write and 0 means read.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| busClk | input | 1 | Clock; all state changes on its rising edge |
| busRstN | input | 1 | Active-low reset |
| reqAddr | input | ADDR_W | Byte address of the transfer in its address phase |
| reqTrans | input | 2 | Transfer type: 00 idle, 01 busy, 10 non-sequential, 11 sequential |
| reqWrite | input | 1 | Direction: 1 write, 0 read |
| reqSize | input | 3 | Transfer size: 0 byte, 1 halfword, 2 word |
| wrData | input | 32 | Write data, valid in the data phase |
| rdData | output | 32 | Read data, valid when a read completes |
| readyOut | output | 1 | Low while the slave extends the data phase |
| errResp | output | 1 | Response: 0 OKAY, 1 ERROR |

## Verification
Every word is written with every legal size at every aligned offset, and each write is read back against a byte-lane model. A wrong lane mask, an offset mix-up or a size mix-up therefore shows up as a data mismatch. Idle and busy cycles are issued with write data present and are followed by read-back, which tells "no access" apart from "access with OKAY". Out-of-range addresses, including one that aliases word 0 in its low bits, and an oversized transfer are checked for the two-cycle error and an unchanged target word. A pipelined write followed by a read, plus a zero-wait copy of the slave driven by the same inputs, separate the overlap of phases and the wait count from plain data correctness.

// File: rtl/ahbw_pkg.sv
package ahbw_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_ACT  = 2'd1,
    ST_ERR1 = 2'd2,
    ST_ERR2 = 2'd3
  } ctrl_state_e;

  // strobes from control to datapath
  typedef struct packed {
    logic latchReq;    // take address/control this edge
    logic finishXfer;  // active transfer completes this cycle
  } strobes_t;

  localparam int BUS_W  = 32;
  localparam int LANES  = BUS_W / 8;

endpackage

// File: rtl/ahbw_ctrl.sv
module ahbw_ctrl
  import ahbw_pkg::*;
#(
  parameter int WAIT_STATES = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic [1:0] reqTrans,
  input  logic       reqOk,
  output strobes_t   strobes,
  output logic       readyOut,
  output logic       errResp
);

  localparam int CNT_W = $clog2(WAIT_STATES + 2);
  localparam logic [CNT_W-1:0] WAIT_LOAD = CNT_W'(WAIT_STATES);

  ctrl_state_e state;
  logic [CNT_W-1:0] waitCnt;

  always_comb begin
    case (state)
      ST_ACT:  readyOut = (waitCnt == '0);
      ST_ERR1: readyOut = 1'b0;
      default: readyOut = 1'b1;
    endcase
    errResp            = (state == ST_ERR1) || (state == ST_ERR2);
    strobes.latchReq   = readyOut;
    strobes.finishXfer = (state == ST_ACT) && (waitCnt == '0);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      waitCnt <= '0;
    end else if (readyOut) begin
      if (reqTrans[1]) begin
        state   <= reqOk ? ST_ACT : ST_ERR1;
        waitCnt <= WAIT_LOAD;
      end else begin
        state <= ST_IDLE;
      end
    end else if (state == ST_ERR1) begin
      state <= ST_ERR2;
    end else begin
      waitCnt <= waitCnt - 1'b1;
    end
  end

endmodule

// File: rtl/ahbw_datapath.sv
module ahbw_datapath
  import ahbw_pkg::*;
#(
  parameter int ADDR_W      = 12,
  parameter int DEPTH_WORDS = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobes_t          strobes,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic              reqWrite,
  input  logic [2:0]        reqSize,
  input  logic [BUS_W-1:0]  wrData,
  output logic              reqOk,
  output logic [BUS_W-1:0]  rdData
);

  localparam int IDX_W = $clog2(DEPTH_WORDS);
  localparam logic [ADDR_W-3:0] WORD_LIMIT = (ADDR_W-2)'(DEPTH_WORDS);

  logic [IDX_W-1:0] idxReg;
  logic [1:0]       laneReg;
  logic [1:0]       sizeReg;
  logic             writeReg;
  logic [LANES-1:0] laneEn;
  logic [BUS_W-1:0] rdWord;

  // decode of the request in its address phase
  always_comb begin
    reqOk = (reqAddr[ADDR_W-1:2] < WORD_LIMIT) && (reqSize <= 3'd2);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      idxReg   <= '0;
      laneReg  <= '0;
      sizeReg  <= '0;
      writeReg <= 1'b0;
    end else if (strobes.latchReq) begin
      idxReg   <= reqAddr[IDX_W+1:2];
      laneReg  <= reqAddr[1:0];
      sizeReg  <= reqSize[1:0];
      writeReg <= reqWrite;
    end
  end

  always_comb begin
    case (sizeReg)
      2'd0:    laneEn = 4'b0001 << laneReg;
      2'd1:    laneEn = laneReg[1] ? 4'b1100 : 4'b0011;
      default: laneEn = 4'b1111;
    endcase
  end

  for (genvar g = 0; g < LANES; g++) begin : gLane
    logic [7:0] laneMem [DEPTH_WORDS];

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        for (int i = 0; i < DEPTH_WORDS; i++) laneMem[i] <= '0;
      end else if (strobes.finishXfer && writeReg && laneEn[g]) begin
        laneMem[idxReg] <= wrData[8*g +: 8];
      end
    end

    assign rdWord[8*g +: 8] = laneMem[idxReg];
  end

  always_comb begin
    rdData = (strobes.finishXfer && !writeReg) ? rdWord : '0;
  end

endmodule

// File: rtl/ahbl_wait_mem.sv
module ahbl_wait_mem
  import ahbw_pkg::*;
#(
  parameter int ADDR_W      = 12,
  parameter int DEPTH_WORDS = 16,
  parameter int WAIT_STATES = 2
) (
  input  logic              busClk,
  input  logic              busRstN,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [1:0]        reqTrans,
  input  logic              reqWrite,
  input  logic [2:0]        reqSize,
  input  logic [31:0]       wrData,
  output logic [31:0]       rdData,
  output logic              readyOut,
  output logic              errResp
);

  strobes_t strobes;
  logic     reqOk;

  ahbw_ctrl #(.WAIT_STATES(WAIT_STATES)) uCtrl (
    .clk      (busClk),
    .rstN     (busRstN),
    .reqTrans (reqTrans),
    .reqOk    (reqOk),
    .strobes  (strobes),
    .readyOut (readyOut),
    .errResp  (errResp)
  );

  ahbw_datapath #(.ADDR_W(ADDR_W), .DEPTH_WORDS(DEPTH_WORDS)) uData (
    .clk      (busClk),
    .rstN     (busRstN),
    .strobes  (strobes),
    .reqAddr  (reqAddr),
    .reqWrite (reqWrite),
    .reqSize  (reqSize),
    .wrData   (wrData),
    .reqOk    (reqOk),
    .rdData   (rdData)
  );

endmodule

// File: rtl/ahbw_checker.sv
module ahbw_checker #(
  parameter int ADDR_W      = 12,
  parameter int DEPTH_WORDS = 16,
  parameter int WAIT_STATES = 2
) (
  input logic              clk,
  input logic              rstN,
  input logic [ADDR_W-1:0] reqAddr,
  input logic [1:0]        reqTrans,
  input logic [2:0]        reqSize,
  input logic [31:0]       rdData,
  input logic              readyOut,
  input logic              errResp
);

  localparam logic [ADDR_W-3:0] WORD_LIMIT = (ADDR_W-2)'(DEPTH_WORDS);

  int  lowCnt;
  logic goodReq;

  assign goodReq = (reqAddr[ADDR_W-1:2] < WORD_LIMIT) && (reqSize <= 3'd2);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) lowCnt <= 0;
    else if (!readyOut && !errResp) lowCnt <= lowCnt + 1;
    else lowCnt <= 0;
  end

  assert_idle_okay_R7: assert property (@(posedge clk) disable iff (!rstN)
    readyOut && !reqTrans[1] |=> readyOut && !errResp);

  assert_err_first_R8: assert property (@(posedge clk) disable iff (!rstN)
    $rose(errResp) |-> !readyOut);

  assert_err_second_R8: assert property (@(posedge clk) disable iff (!rstN)
    errResp && !readyOut |=> errResp && readyOut);

  assert_bad_req_err_R9: assert property (@(posedge clk) disable iff (!rstN)
    readyOut && reqTrans[1] && !goodReq |=> errResp && !readyOut);

  assert_wait_bound_R3: assert property (@(posedge clk) disable iff (!rstN)
    !readyOut && !errResp |-> lowCnt < WAIT_STATES);

  assert_rd_quiet_R4: assert property (@(posedge clk) disable iff (!rstN)
    !readyOut |-> rdData == 32'd0);

  if (WAIT_STATES > 0) begin : gWaitChk
    assert_wait_start_R3: assert property (@(posedge clk) disable iff (!rstN)
      readyOut && reqTrans[1] && goodReq |=> !readyOut && !errResp);
  end else begin : gNoWaitChk
    assert_no_wait_R3: assert property (@(posedge clk) disable iff (!rstN)
      !errResp |-> readyOut);
  end

endmodule

bind ahbl_wait_mem ahbw_checker #(
  .ADDR_W(ADDR_W), .DEPTH_WORDS(DEPTH_WORDS), .WAIT_STATES(WAIT_STATES)
) uChecker (
  .clk      (busClk),
  .rstN     (busRstN),
  .reqAddr  (reqAddr),
  .reqTrans (reqTrans),
  .reqSize  (reqSize),
  .rdData   (rdData),
  .readyOut (readyOut),
  .errResp  (errResp)
);

// File: tb/tb_ahbl_wait_mem.sv
`timescale 1ns/1ps
module tb_ahbl_wait_mem;

  localparam int WAITS = 2;
  localparam int DEPTH = 16;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [11:0] reqAddr = '0;
  logic [1:0]  reqTrans = 2'b00;
  logic        reqWrite = 1'b0;
  logic [2:0]  reqSize = 3'd0;
  logic [31:0] wrData = '0;
  logic [31:0] rdData, rdData0;
  logic        readyOut, readyOut0, errResp, errResp0;

  int total = 0;
  int fails = 0;
  logic [31:0] model [DEPTH];

  always #4 clk = ~clk;

  ahbl_wait_mem #(.ADDR_W(12), .DEPTH_WORDS(DEPTH), .WAIT_STATES(WAITS)) dut (
    .busClk(clk), .busRstN(rstN), .reqAddr(reqAddr), .reqTrans(reqTrans),
    .reqWrite(reqWrite), .reqSize(reqSize), .wrData(wrData),
    .rdData(rdData), .readyOut(readyOut), .errResp(errResp));

  ahbl_wait_mem #(.ADDR_W(12), .DEPTH_WORDS(DEPTH), .WAIT_STATES(0)) dut0 (
    .busClk(clk), .busRstN(rstN), .reqAddr(reqAddr), .reqTrans(reqTrans),
    .reqWrite(reqWrite), .reqSize(reqSize), .wrData(wrData),
    .rdData(rdData0), .readyOut(readyOut0), .errResp(errResp0));

  task automatic check(input logic ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // one non-overlapped transfer; returns waits, data and response
  task automatic xfer(input logic [11:0] a, input logic w, input logic [2:0] s,
                      input logic [1:0] t, input logic [31:0] d,
                      output int waits, output logic [31:0] rd, output logic rsp,
                      output logic zRdy, output logic [31:0] zRd);
    @(negedge clk);
    reqAddr = a; reqWrite = w; reqSize = s; reqTrans = t;
    @(posedge clk);
    @(negedge clk);
    reqTrans = 2'b00; wrData = d;
    zRdy = readyOut0; zRd = rdData0;
    waits = 0;
    while (!readyOut && waits < 20) begin
      waits++;
      @(negedge clk);
    end
    rd = rdData; rsp = errResp;
  endtask

  function automatic logic [3:0] laneMask(input logic [1:0] off, input logic [2:0] s);
    case (s)
      3'd0:    return 4'b0001 << off;
      3'd1:    return off[1] ? 4'b1100 : 4'b0011;
      default: return 4'b1111;
    endcase
  endfunction

  task automatic readWord(input int idx, input string tag);
    int wt; logic [31:0] rd, zr; logic rsp, zy;
    xfer(12'(idx * 4), 1'b0, 3'd2, 2'b10, 32'h0, wt, rd, rsp, zy, zr);
    check(rd == model[idx], tag, rd, model[idx]);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    fails++; total++;
    $display("FAIL watchdog expired actual=%h expected=%h", 32'd0, 32'd1);
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin : main
    int wt; logic [31:0] rd, zr, d; logic rsp, zy; logic [3:0] m;
    for (int i = 0; i < DEPTH; i++) model[i] = '0;
    repeat (3) @(posedge clk);
    @(negedge clk); rstN = 1'b1;
    // R1 reset state
    @(negedge clk);
    check(readyOut == 1'b1, "R1 readyOut after reset", 32'(readyOut), 32'd1);
    check(errResp == 1'b0, "R1 errResp after reset", 32'(errResp), 32'd0);
    check(rdData == 32'd0, "R1 rdData after reset", rdData, 32'd0);
    readWord(5, "R1 storage cleared");

    // R6 R5 R3 exhaustive sweep: every word, size and aligned offset
    for (int idx = 0; idx < DEPTH; idx++) begin
      for (int s = 0; s < 3; s++) begin
        for (int off = 0; off < 4; off += (1 << s)) begin
          d = 32'hA5C3_0000 ^ (32'(idx) * 32'h0101_0101) ^ (32'(s) * 32'h0000_1111)
              ^ (32'(off) * 32'h0102_0304);
          xfer(12'(idx * 4 + off), 1'b1, 3'(s), (off[0] ? 2'b11 : 2'b10), d,
               wt, rd, rsp, zy, zr);
          m = laneMask(2'(off), 3'(s));
          for (int k = 0; k < 4; k++) if (m[k]) model[idx][8*k +: 8] = d[8*k +: 8];
          check(wt == WAITS && rsp == 1'b0, "R3 write waits/okay R10",
                32'(wt), 32'(WAITS));
          check(zy == 1'b1, "R3 zero-wait copy ready", 32'(zy), 32'd1);
          xfer(12'(idx * 4), 1'b0, 3'd2, 2'b11, 32'hDEAD_BEEF, wt, rd, rsp, zy, zr);
          check(rd == model[idx], "R6 lane write readback", rd, model[idx]);
          check(wt == WAITS, "R3 read waits", 32'(wt), 32'(WAITS));
          check(zr == model[idx], "R4 zero-wait copy read", zr, model[idx]);
        end
      end
    end

    // R7 idle and busy carry write data but change nothing
    for (int t = 0; t < 2; t++) begin
      xfer(12'h008, 1'b1, 3'd2, 2'(t), 32'h1234_5678, wt, rd, rsp, zy, zr);
      check(wt == 0 && rsp == 1'b0, "R7 idle/busy zero-wait okay", 32'(wt), 32'd0);
      check(rd == 32'd0, "R7 idle/busy no read data", rd, 32'd0);
      readWord(2, "R7 idle/busy no write");
    end

    // R8 out of range: index 16 aliases word 0, and top of space
    xfer(12'h040, 1'b1, 3'd2, 2'b10, 32'hFFFF_FFFF, wt, rd, rsp, zy, zr);
    check(wt == 1 && rsp == 1'b1, "R8 error waits then resp", 32'(wt), 32'd1);
    check(readyOut && errResp, "R8 second error cycle", {30'd0, readyOut, errResp}, 32'd3);
    readWord(0, "R8 no write on error");
    xfer(12'hFFC, 1'b0, 3'd2, 2'b10, 32'h0, wt, rd, rsp, zy, zr);
    check(wt == 1 && rsp == 1'b1, "R8 read out of range error", 32'(wt), 32'd1);

    // R9 oversized transfer
    xfer(12'h00C, 1'b1, 3'd3, 2'b10, 32'h0BAD_0BAD, wt, rd, rsp, zy, zr);
    check(wt == 1 && rsp == 1'b1, "R9 oversize error", 32'(wt), 32'd1);
    readWord(3, "R9 no write on oversize");

    // R2 pipelined write then read to the same word
    @(negedge clk);
    reqAddr = 12'h014; reqWrite = 1'b1; reqSize = 3'd2; reqTrans = 2'b10;
    @(posedge clk);
    @(negedge clk);
    wrData = 32'hC0DE_F00D;
    reqAddr = 12'h014; reqWrite = 1'b0; reqSize = 3'd2; reqTrans = 2'b10;
    wt = 0;
    while (!readyOut && wt < 20) begin wt++; @(negedge clk); end
    check(wt == WAITS, "R2 pipelined write waits", 32'(wt), 32'(WAITS));
    @(posedge clk);
    @(negedge clk);
    reqTrans = 2'b00;
    wt = 0;
    while (!readyOut && wt < 20) begin wt++; @(negedge clk); end
    model[5] = 32'hC0DE_F00D;
    check(rdData == 32'hC0DE_F00D, "R2 read sees prior write", rdData, 32'hC0DE_F00D);
    check(wt == WAITS, "R2 pipelined read waits", 32'(wt), 32'(WAITS));

    // R4 full-word reads of every word
    for (int idx = 0; idx < DEPTH; idx++) readWord(idx, "R4 final readback");

    @(negedge clk);
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

endmodule